// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns single register requests from a host into serial management frames on a two-wire management bus: a clock (MDC) and a bidirectional data line (MDIO). The line is carried as a data output, an output enable and a data input, and the pad is outside the block. The host gives a 5-bit PHY address, a 5-bit register address, a read/write flag and, for a write, 16 data bits. The block then runs one complete frame on its own and pulses `done` when the frame ends. For a read, the register value is on `rdata` from that cycle.

Every frame starts with a full 32-bit preamble of ones. A read sends a fixed 16-bit header, then releases the line and clocks a 20-bit window. The 16-bit register value is taken from inside that window. A write sends a 32-bit body that carries its own turnaround bits, then releases the line for two more clocks. A parameter sets each MDC half-period as a number of system clocks. Its default is derived from the system clock rate, so that MDC stays at or below 2.5 MHz.

Top module: `mdio_frame_master`

## Requirements
- R1: After the synchronous active-low reset, `busy`, `done`, `mdc` and `mdio_oe` are all 0. Whenever `busy` is 0, `mdc` and `mdio_oe` stay 0.
- R2: A request is taken only in a cycle with `req`=1 and `busy`=0. The address, data and `rd_nwr` fields are captured in that cycle, and `busy` is 1 from the next cycle. A `req` pulse while `busy`=1 has no effect on the frame in progress, and no further frame follows it.
- R3: Every frame begins with 32 MDC clocks during which `mdio_o`=1 and `mdio_oe`=1.
- R4: For a read (`rd_nwr`=1), the 16 clocks after the preamble have `mdio_oe`=1 and carry the bits 1,1,0,1,1,0, then `phy_addr[4:0]`, then `reg_addr[4:0]`, most significant bit first.
- R5: For a read, the header is followed by 20 clocks with `mdio_oe`=0. A read frame has exactly 68 rising MDC edges.
- R6: During the 20 released clocks of a read, `mdio_i` is sampled in the system cycle in which MDC rises. The samples form a 20-bit word, first sample as the most significant bit, and `rdata` = word[16:1].
- R7: For a write (`rd_nwr`=0), the preamble is followed by 32 clocks with `mdio_oe`=1. They carry 0,1,0,1, then `phy_addr[4:0]`, `reg_addr[4:0]`, 1,0, then `wdata[15:0]`, most significant bit first. Two clocks with `mdio_oe`=0 follow, for 66 rising edges in total.
- R8: `mdio_o` and `mdio_oe` change only while `mdc` is low, and hold steady for the whole high phase.
- R9: Each MDC high phase and each low phase between clocks lasts `HALF_DIV` system clocks. The default `HALF_DIV` is ceil(`CLK_HZ`/(2·`MDC_MAX_HZ`)), which is 40 at 200 MHz and 2.5 MHz, giving an MDC period of at least 400 ns.
- R10: `done` is high for exactly one cycle: the system cycle in which `mdc` returns low after the last clock of the frame. `busy` is 0 in that cycle, and `rdata` is valid from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken while busy is low |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| mdio_i | input | 1 | Sampled management data line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Register value from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data line |

## Verification
The bench walks a single one through both address fields and through the write data, and also sends all-zero and all-one values. A header with swapped or misplaced bits would then show up as a mismatch at a particular clock. For reads, the simulated PHY drives a different 20-bit reply each time. The expected `rdata` is that reply's bits 16 to 1. A design that kept the wrong end of the window, or sampled one clock late, would return a shifted value. The bench counts rising edges and measures every half-period against 40 system clocks, so a missing or extra turnaround clock, or a divider that is off by one, is caught. One frame gets a second request with every field inverted while it is running. A design that accepted that request would change the bit pattern or start an extra frame after `done`.

// File: rtl/mdio_pkg.sv
// Shared frame geometry and command builder for the management frame master.
// Assumes: fixed frame layouts (full preamble, 16-bit read header, 32-bit
// write body), MSB-first transmission.
package mdio_pkg;
    localparam int PRE_BITS     = 32;
    localparam int RD_HDR_BITS  = 16;
    localparam int RD_WIN_BITS  = 20;
    localparam int WR_BODY_BITS = 32;
    localparam int WR_TAIL_BITS = 2;
    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 16;

    localparam int RD_OE_BITS   = PRE_BITS + RD_HDR_BITS;
    localparam int WR_OE_BITS   = PRE_BITS + WR_BODY_BITS;
    localparam int RD_TOTAL     = RD_OE_BITS + RD_WIN_BITS;
    localparam int WR_TOTAL     = WR_OE_BITS + WR_TAIL_BITS;
    localparam int SHIFT_BITS   = WR_OE_BITS;
    localparam int IDX_W        = $clog2(RD_TOTAL);
    // Window positions holding word bits DATA_W..1 (word bit = RD_WIN_BITS-1-pos)
    localparam int CAP_FIRST    = RD_OE_BITS + (RD_WIN_BITS - 1 - DATA_W);
    localparam int CAP_LAST     = CAP_FIRST + DATA_W - 1;

    // Builds the 32 bits sent after the preamble; a read header fills the top half.
    function automatic logic [WR_BODY_BITS-1:0] build_cmd(
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg,
        input logic [DATA_W-1:0] wd
    );
        if (rd)
            build_cmd = {2'b11, 2'b01, 2'b10, phy, rg, {DATA_W{1'b0}}};
        else
            build_cmd = {2'b01, 2'b01, phy, rg, 2'b10, wd};
    endfunction
endpackage

// File: rtl/mdio_half_timer.sv
// Half-period timer: while run is high, pulses tick once every HALF_DIV
// system clocks. Assumes HALF_DIV >= 1; restart or !run returns it to zero.
module mdio_half_timer #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_TOP);

    // Count system clocks within the current MDC half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdio_bit_seq.sv
// Bit sequencer: owns busy, the MDC level and the bit index. Each bit is a
// low phase then a high phase, each one timer tick long; done follows the
// falling edge of the last bit. Assumes start only arrives while idle.
module mdio_bit_seq
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic             tick,
    output logic             busy,
    output logic             mdc,
    output logic             is_rd,
    output logic [IDX_W-1:0] bit_idx,
    output logic             rise_evt,
    output logic             fall_evt,
    output logic             done
);
    localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(RD_TOTAL - 1);
    localparam logic [IDX_W-1:0] WR_LAST = IDX_W'(WR_TOTAL - 1);

    logic last_bit;

    assign rise_evt = busy && tick && !mdc;
    assign fall_evt = busy && tick && mdc;
    assign last_bit = (bit_idx == (is_rd ? RD_LAST : WR_LAST));

    // Advance the phase and bit index, and end the frame after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mdc     <= 1'b0;
            is_rd   <= 1'b0;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                mdc     <= 1'b0;
                is_rd   <= start_rd;
                bit_idx <= '0;
            end else if (rise_evt) begin
                mdc <= 1'b1;
            end else if (fall_evt) begin
                mdc <= 1'b0;
                if (last_bit) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_shift_path.sv
// Data path: a transmit shift register (preamble plus command) that shifts on
// each falling MDC edge, the output-enable decode, and a receive shift
// register that keeps only the 16 window samples forming the register value.
// Assumes load coincides with the sequencer start.
module mdio_shift_path
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] rg,
    input  logic [DATA_W-1:0] wd,
    input  logic              busy,
    input  logic              is_rd,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [IDX_W-1:0] RD_OE_END = IDX_W'(RD_OE_BITS);
    localparam logic [IDX_W-1:0] WR_OE_END = IDX_W'(WR_OE_BITS);
    localparam logic [IDX_W-1:0] CAP_LO    = IDX_W'(CAP_FIRST);
    localparam logic [IDX_W-1:0] CAP_HI    = IDX_W'(CAP_LAST);

    logic [SHIFT_BITS-1:0] tx_sr;
    logic                  in_cap;

    assign mdio_o  = tx_sr[SHIFT_BITS-1];
    assign mdio_oe = busy && (bit_idx < (is_rd ? RD_OE_END : WR_OE_END));
    assign in_cap  = is_rd && (bit_idx >= CAP_LO) && (bit_idx <= CAP_HI);

    // Load the frame on accept, then move to the next bit at each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (load)
            tx_sr <= {{PRE_BITS{1'b1}}, build_cmd(ld_rd, phy, rg, wd)};
        else if (fall_evt)
            tx_sr <= {tx_sr[SHIFT_BITS-2:0], 1'b0};
    end

    // Capture the register value bits of the read window, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rise_evt && in_cap)
            rdata <= {rdata[DATA_W-2:0], mdio_i};
    end
endmodule

// File: rtl/mdio_frame_master.sv
// Management frame master top: accepts one request while idle and runs a
// full read or write frame on MDC/MDIO. HALF_DIV defaults to the smallest
// half-period (in system clocks) that keeps MDC at or below MDC_MAX_HZ.
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int HALF_DIV   = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic             accept;
    logic             tick;
    logic             is_rd;
    logic [IDX_W-1:0] bit_idx;
    logic             rise_evt;
    logic             fall_evt;

    assign accept = req && !busy;

    mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (accept),
        .tick    (tick)
    );

    mdio_bit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_rd (rd_nwr),
        .tick     (tick),
        .busy     (busy),
        .mdc      (mdc),
        .is_rd    (is_rd),
        .bit_idx  (bit_idx),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .done     (done)
    );

    mdio_shift_path u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .ld_rd    (rd_nwr),
        .phy      (phy_addr),
        .rg       (reg_addr),
        .wd       (wdata),
        .busy     (busy),
        .is_rd    (is_rd),
        .bit_idx  (bit_idx),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (rdata)
    );
endmodule

// File: rtl/mdio_frame_master_chk.sv
// Protocol checker for mdio_frame_master: idle quietness, accept handshake,
// bit-cell stability, half-period length and the done pulse.
module mdio_frame_master_chk #(
    parameter int HALF_DIV = 40
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    logic [31:0] run_len;
    logic        mdc_q;

    // Length of the current unchanged MDC level, in system clocks minus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            mdc_q   <= 1'b0;
        end else begin
            mdc_q   <= mdc;
            run_len <= (mdc != mdc_q) ? 32'd0 : run_len + 32'd1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!mdc && !mdio_oe && !busy && !done));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    a_r8_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r9_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (run_len == 32'(HALF_DIV - 1)));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mdc));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
    localparam int HALF = (200_000_000 + 2 * 2_500_000 - 1) / (2 * 2_500_000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    mdio_frame_master dut (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .mdio_i(mdio_i), .busy(busy), .done(done), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Monitor state
    bit          mon_en = 0;
    logic        prev_mdc = 0;
    int          rises, hi_w, lo_w, width_err, stab_err, done_cnt;
    logic        hi_o, hi_oe, done_busy, done_mdc;
    logic [15:0] done_rdata;
    int          done_rises;
    logic [19:0] resp20;
    logic        got_o [0:67];
    logic        got_oe[0:67];
    logic        exp_o [0:67];
    logic        exp_oe[0:67];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    // Line monitor and PHY model, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (mdc && !prev_mdc) begin
                if (rises < 68) begin
                    got_o[rises]  = mdio_o;
                    got_oe[rises] = mdio_oe;
                end
                rises++;
                if (rises > 1 && lo_w != HALF) width_err++;
                hi_w = 1; hi_o = mdio_o; hi_oe = mdio_oe;
            end else if (mdc) begin
                hi_w++;
                if (mdio_o !== hi_o || mdio_oe !== hi_oe) stab_err++;
            end else if (prev_mdc) begin
                if (hi_w != HALF) width_err++;
                lo_w = 1;
                if (rises >= 48 && rises < 68) mdio_i = resp20[19 - (rises - 48)];
            end else begin
                lo_w++;
            end
            if (done) begin
                done_cnt++;
                done_rdata = rdata; done_busy = busy; done_mdc = mdc; done_rises = rises;
            end
        end
        prev_mdc = mdc;
    end

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [19:0] r20, input bit inject);
        logic [31:0] cmd;
        int total, oe_n, pre_bad, hdr_bad, oe_bad, waitc;
        total = rd ? 68 : 66;
        oe_n  = rd ? 48 : 64;
        cmd = rd ? {2'b11, 2'b01, 2'b10, phy, rg, 16'h0000}
                 : {2'b01, 2'b01, phy, rg, 2'b10, wd};
        for (int i = 0; i < 68; i++) begin
            exp_oe[i] = (i < oe_n);
            exp_o[i]  = (i < 32) ? 1'b1 : ((i < oe_n) ? cmd[31 - (i - 32)] : 1'b0);
            got_o[i] = 1'bx; got_oe[i] = 1'bx;
        end
        rises = 0; width_err = 0; stab_err = 0; done_cnt = 0; hi_w = 0; lo_w = 0;
        resp20 = r20; mdio_i = ~r20[0];
        mon_en = 1;
        @(negedge clk);
        req = 1; rd_nwr = rd; phy_addr = phy; reg_addr = rg; wdata = wd;
        @(negedge clk);
        req = 0; phy_addr = ~phy; reg_addr = ~rg; wdata = ~wd; rd_nwr = ~rd;
        if (inject) begin
            repeat (300) @(negedge clk);
            chk(busy === 1'b1, "R2 busy mid-frame", busy, 1);
            req = 1;
            @(negedge clk);
            req = 0;
        end
        waitc = 0;
        while (done_cnt == 0 && waitc < 8000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (4 * HALF) @(negedge clk);
        mon_en = 0;
        pre_bad = 0; hdr_bad = 0; oe_bad = 0;
        for (int i = 0; i < total; i++) begin
            if (got_oe[i] !== exp_oe[i]) oe_bad++;
            if (exp_oe[i] && got_o[i] !== exp_o[i]) begin
                if (i < 32) pre_bad++; else hdr_bad++;
            end
        end
        chk(pre_bad == 0, "R3 preamble bits wrong", pre_bad, 0);
        if (rd) begin
            chk(hdr_bad == 0, "R4 read header bits wrong", hdr_bad, 0);
            chk(oe_bad == 0, "R5 read enable pattern wrong", oe_bad, 0);
            chk(done_rises == 68, "R5 read clock count", done_rises, 68);
            chk(done_rdata === r20[16:1], "R6 read data", done_rdata, r20[16:1]);
        end else begin
            chk(hdr_bad == 0, "R7 write body bits wrong", hdr_bad, 0);
            chk(oe_bad == 0, "R7 write enable pattern wrong", oe_bad, 0);
            chk(done_rises == 66, "R7 write clock count", done_rises, 66);
        end
        chk(rises == total, "R2 no extra frame after done", rises, total);
        chk(stab_err == 0, "R8 data moved while mdc high", stab_err, 0);
        chk(width_err == 0, "R9 half-period length", width_err, 0);
        chk(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
        chk(done_busy === 1'b0 && done_mdc === 1'b0, "R10 busy/mdc at done",
            {done_busy, done_mdc}, 0);
        chk(busy === 1'b0 && mdio_oe === 1'b0 && mdc === 1'b0, "R1 idle after frame",
            {busy, mdio_oe, mdc}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 reset mdc/oe", {mdc, mdio_oe}, 0);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {busy, done}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(mdc === 1'b0 && busy === 1'b0, "R1 idle after reset", {mdc, busy}, 0);
        chk(2 * HALF * 5 >= 400, "R9 mdc period ns", 2 * HALF * 5, 400);
        // Reads: walking one in the PHY address, varied register and reply.
        for (int k = 0; k < 7; k++) begin
            logic [4:0] p;
            logic [19:0] r;
            p = (k < 5) ? 5'(1 << k) : ((k == 5) ? 5'h00 : 5'h1F);
            r = 20'h9A5C3 ^ (20'h1_1111 * k[19:0]) ^ {k[3:0], 16'h0};
            run_frame(1'b1, p, ~p ^ 5'(k), 16'h0, r, 1'b0);
        end
        // Writes: walking one in register address and data bits.
        for (int k = 0; k < 7; k++) begin
            logic [4:0] g;
            logic [15:0] d;
            g = (k < 5) ? 5'(1 << k) : ((k == 5) ? 5'h1F : 5'h00);
            d = (k < 5) ? 16'(16'h0001 << (3 * k)) : ((k == 5) ? 16'hFFFF : 16'h0000);
            run_frame(1'b0, 5'(k * 5), g, d ^ 16'hA050, 20'h0, 1'b0);
        end
        // Requests arriving mid-frame are ignored.
        run_frame(1'b1, 5'h0A, 5'h15, 16'h0, 20'h5_3C6A, 1'b1);
        run_frame(1'b0, 5'h15, 5'h0A, 16'hC3A5, 20'h0, 1'b1);
        report();
    end
endmodule